// File: doc/BRIEF.md
# 800x600 Raster Timing and Scan Address Generator

This block paces the scan of an 800x600 picture from a 40 MHz pixel clock. A pixel counter advances on every clock and runs through a 1056-clock line. A line counter advances each time the pixel counter returns to zero, and runs through a 628-line frame. Both counters wrap freely. From these counts the block produces a horizontal and a vertical sync pulse, both active high, and a flag that marks the visible picture area.

The block also produces the linear read address into a frame buffer that stores one word per visible pixel, row after row. It is meant to sit between a free-running pixel clock and the read port of that buffer. The address, the flag and both sync pulses come from one register stage. They are all taken from the same sample of the counters, so they line up with each other one clock after the counter values they describe. The picture geometry is held in parameters. The defaults give the 800x600 timing, and a smaller geometry keeps the same behaviour.

Top module: `scan_timing_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, at the next clock edge `hcount` and `vcount` become 0, `hsync`, `vsync` and `active` become 0, and `fbAddr` becomes 0.
- R2: `hcount` increases by one on every clock from 0 up to 1055, and after 1055 it returns to 0.
- R3: `vcount` increases by one on the clock where `hcount` goes from 1055 to 0, and holds on every other clock. After line 627 it returns to 0 at that same clock.
- R4: `hsync` is high exactly when the pixel count seen one clock earlier is in 840..967 inclusive. That gives 840 low, 128 high and 88 low clocks per line.
- R5: `vsync` is high exactly when the line count seen one clock earlier is in 601..604 inclusive. That gives 601 low, 4 high and 23 low lines per frame.
- R6: `active` is high exactly when the counts seen one clock earlier satisfy pixel < 800 and line < 600.
- R7: When `active` is high, `fbAddr` equals pixel + 800*line for the counts seen one clock earlier. When `active` is low, `fbAddr` is 0.
- R8: At the end of a frame, the pixel wrap and the line wrap take effect on the same clock, so (1055, 627) is followed by (0, 0). The sync, flag and address outputs then restart from the top-left pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz for the default geometry) |
| rst | input | 1 | Synchronous reset, active high |
| hcount | output | 11 | Current pixel count within the line |
| vcount | output | 10 | Current line count within the frame |
| hsync | output | 1 | Horizontal sync pulse, active high, registered |
| vsync | output | 1 | Vertical sync pulse, active high, registered |
| active | output | 1 | Visible picture flag, registered |
| fbAddr | output | 19 | Frame buffer read address, 0 outside the picture |

## Verification
The case that needs care is the last clock of a frame. On that clock the pixel wrap and the line wrap both happen, and the line counter has to return to zero instead of stepping past its limit. A full default frame is far too long for the run, so a second instance with a small geometry is driven through several whole frames. It is compared on every clock with a model computed from the cycle count. That covers both wraps, the vertical pulse and the restart of the address at zero. The default instance is judged at hand-computed edge cycles inside its first lines, and by a reset applied in the middle of a horizontal pulse.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

  // Strobes passed from the counter control to the output datapath
  typedef struct packed {
    logic hWrap;   // pixel counter at its last value
    logic vWrap;   // line counter at its last value
    logic hVis;    // pixel count inside visible width
    logic vVis;    // line count inside visible height
    logic hPulse;  // pixel count inside horizontal pulse window
    logic vPulse;  // line count inside vertical pulse window
  } scanCtl_t;

endpackage

// File: rtl/scan_counters.sv
module scan_counters
  import scan_timing_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FRONT  = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BACK   = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FRONT  = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BACK   = 23,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hCnt,
  output logic [VW-1:0] vCnt,
  output scanCtl_t      ctl
);

  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FRONT;
  localparam int VS_END   = VS_START + V_SYNC;

  // Decode the current counts into strobes
  always_comb begin
    ctl.hWrap  = (hCnt == HW'(H_TOTAL - 1));
    ctl.vWrap  = (vCnt == VW'(V_TOTAL - 1));
    ctl.hVis   = (hCnt <  HW'(H_ACTIVE));
    ctl.vVis   = (vCnt <  VW'(V_ACTIVE));
    ctl.hPulse = (hCnt >= HW'(HS_START)) && (hCnt < HW'(HS_END));
    ctl.vPulse = (vCnt >= VW'(VS_START)) && (vCnt < VW'(VS_END));
  end

  // Pixel counter
  always_ff @(posedge clk) begin
    if (rst)            hCnt <= '0;
    else if (ctl.hWrap) hCnt <= '0;
    else                hCnt <= hCnt + HW'(1);
  end

  // Line counter, advances on the pixel wrap
  always_ff @(posedge clk) begin
    if (rst) vCnt <= '0;
    else if (ctl.hWrap) begin
      if (ctl.vWrap) vCnt <= '0;
      else           vCnt <= vCnt + VW'(1);
    end
  end

  a_r2_h_range: assert property (@(posedge clk) disable iff (rst)
    hCnt < HW'(H_TOTAL));
  a_r2_h_step: assert property (@(posedge clk) disable iff (rst)
    (hCnt != HW'(H_TOTAL - 1)) |=> (hCnt == $past(hCnt) + HW'(1)));
  a_r3_v_hold: assert property (@(posedge clk) disable iff (rst)
    (hCnt != HW'(H_TOTAL - 1)) |=> $stable(vCnt));
  a_r3_v_step: assert property (@(posedge clk) disable iff (rst)
    (hCnt == HW'(H_TOTAL - 1) && vCnt != VW'(V_TOTAL - 1))
      |=> (hCnt == '0 && vCnt == $past(vCnt) + VW'(1)));
  a_r8_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (hCnt == HW'(H_TOTAL - 1) && vCnt == VW'(V_TOTAL - 1))
      |=> (hCnt == '0 && vCnt == '0));

endmodule

// File: rtl/scan_outputs.sv
module scan_outputs
  import scan_timing_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int V_ACTIVE = 600,
  parameter int HW       = 11,
  parameter int VW       = 10,
  localparam int AW      = $clog2(H_ACTIVE * V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hCnt,
  input  logic [VW-1:0] vCnt,
  input  scanCtl_t      ctl,
  output logic          hsyncQ,
  output logic          vsyncQ,
  output logic          activeQ,
  output logic [AW-1:0] addrQ
);

  logic [AW-1:0] lineBase;
  logic [AW-1:0] addrNext;
  logic          visNext;

  // Row start address: shift-and-add for the default width, product otherwise
  generate
    if (H_ACTIVE == 800) begin : g_shiftAdd
      logic [AW-1:0] vExt;
      assign vExt     = AW'(vCnt);
      assign lineBase = (vExt << 9) + (vExt << 8) + (vExt << 5);
    end else begin : g_product
      assign lineBase = AW'(H_ACTIVE) * AW'(vCnt);
    end
  endgenerate

  assign visNext  = ctl.hVis && ctl.vVis;
  assign addrNext = visNext ? (AW'(hCnt) + lineBase) : '0;

  // One register stage keeps all outputs aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncQ  <= 1'b0;
      vsyncQ  <= 1'b0;
      activeQ <= 1'b0;
      addrQ   <= '0;
    end else begin
      hsyncQ  <= ctl.hPulse;
      vsyncQ  <= ctl.vPulse;
      activeQ <= visNext;
      addrQ   <= addrNext;
    end
  end

  a_r7_blank_addr: assert property (@(posedge clk) disable iff (rst)
    !activeQ |-> (addrQ == '0));
  a_r4_hsync_blank: assert property (@(posedge clk) disable iff (rst)
    hsyncQ |-> !activeQ);
  a_r5_vsync_blank: assert property (@(posedge clk) disable iff (rst)
    vsyncQ |-> !activeQ);
  a_r7_addr_range: assert property (@(posedge clk) disable iff (rst)
    addrQ < AW'(H_ACTIVE * V_ACTIVE));

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FRONT  = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BACK   = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FRONT  = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BACK   = 23,
  localparam int HW      = $clog2(H_ACTIVE + H_FRONT + H_SYNC + H_BACK),
  localparam int VW      = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK),
  localparam int AW      = $clog2(H_ACTIVE * V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic [AW-1:0] fbAddr
);

  scanCtl_t ctl;

  scan_counters #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) i_counters (
    .clk  (clk),
    .rst  (rst),
    .hCnt (hcount),
    .vCnt (vcount),
    .ctl  (ctl)
  );

  scan_outputs #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .HW(HW), .VW(VW)
  ) i_outputs (
    .clk     (clk),
    .rst     (rst),
    .hCnt    (hcount),
    .vCnt    (vcount),
    .ctl     (ctl),
    .hsyncQ  (hsync),
    .vsyncQ  (vsync),
    .activeQ (active),
    .addrQ   (fbAddr)
  );

endmodule

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int kCnt    = 0;   // clock edges since reset release
  bit smallOn = 1'b0;

  // Default geometry instance
  logic [10:0] hD;
  logic [9:0]  vD;
  logic        hsD, vsD, actD;
  logic [18:0] adD;

  scan_timing_gen i_scan_timing_gen (
    .clk(clk), .rst(rst), .hcount(hD), .vcount(vD),
    .hsync(hsD), .vsync(vsD), .active(actD), .fbAddr(adD)
  );

  // Small geometry: line 8+2+4+3=17, frame 6+1+2+3=12 lines
  logic [4:0] hS;
  logic [3:0] vS;
  logic       hsS, vsS, actS;
  logic [5:0] adS;

  scan_timing_gen #(
    .H_ACTIVE(8), .H_FRONT(2), .H_SYNC(4), .H_BACK(3),
    .V_ACTIVE(6), .V_FRONT(1), .V_SYNC(2), .V_BACK(3)
  ) i_small (
    .clk(clk), .rst(rst), .hcount(hS), .vcount(vS),
    .hsync(hsS), .vsync(vsS), .active(actS), .fbAddr(adS)
  );

  always @(posedge clk) begin
    if (rst) kCnt <= 0;
    else     kCnt <= kCnt + 1;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at k=%0d: actual %0d expected %0d", req, what, kCnt, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] k;
    logic [31:0] h;
    logic [31:0] v;
    logic        hs;
    logic        vs;
    logic        act;
    logic [31:0] addr;
  } vec_t;

  // Outputs after edge k describe the counts after edge k-1
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'd1,    32'd1,   32'd0, 1'b0, 1'b0, 1'b1, 32'd0},
    '{32'd800,  32'd800, 32'd0, 1'b0, 1'b0, 1'b1, 32'd799},
    '{32'd801,  32'd801, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{32'd841,  32'd841, 32'd0, 1'b1, 1'b0, 1'b0, 32'd0},
    '{32'd968,  32'd968, 32'd0, 1'b1, 1'b0, 1'b0, 32'd0},
    '{32'd969,  32'd969, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{32'd1056, 32'd0,   32'd1, 1'b0, 1'b0, 1'b0, 32'd0},
    '{32'd1057, 32'd1,   32'd1, 1'b0, 1'b0, 1'b1, 32'd800},
    '{32'd1058, 32'd2,   32'd1, 1'b0, 1'b0, 1'b1, 32'd801},
    '{32'd2118, 32'd6,   32'd2, 1'b0, 1'b0, 1'b1, 32'd1605},
    '{32'd3968, 32'd800, 32'd3, 1'b0, 1'b0, 1'b1, 32'd3199}
  };

  // R8 and full-frame model for the small instance, every clock
  always @(negedge clk) begin
    if (smallOn && !rst && kCnt >= 1 && kCnt <= 700) begin
      int ph, pv, eh, ev;
      bit eAct;
      ph = (kCnt - 1) % 17;
      pv = ((kCnt - 1) / 17) % 12;
      eh = kCnt % 17;
      ev = (kCnt / 17) % 12;
      eAct = (ph < 8) && (pv < 6);
      check("R2", int'(hS), eh, "small hcount");
      check("R3", int'(vS), ev, "small vcount");
      check("R4", int'(hsS), int'(ph >= 10 && ph < 14), "small hsync");
      check("R5", int'(vsS), int'(pv >= 7 && pv < 9), "small vsync");
      check("R6", int'(actS), int'(eAct), "small active");
      check("R7", int'(adS), eAct ? ph + 8 * pv : 0, "small address");
      if (kCnt % 204 == 0)
        check("R8", int'(hS) + int'(vS), 0, "small frame wrap to origin");
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(hD), 0, "hcount in reset");
    check("R1", int'(vD), 0, "vcount in reset");
    check("R1", int'(hsD) + int'(vsD) + int'(actD), 0, "sync/active in reset");
    check("R1", int'(adD), 0, "address in reset");
    rst = 1'b0;
    smallOn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      while (kCnt != int'(VECS[i].k)) @(negedge clk);
      check("R2", int'(hD), int'(VECS[i].h), "hcount");
      check("R3", int'(vD), int'(VECS[i].v), "vcount");
      check("R4", int'(hsD), int'(VECS[i].hs), "hsync");
      check("R5", int'(vsD), int'(VECS[i].vs), "vsync");
      check("R6", int'(actD), int'(VECS[i].act), "active");
      check("R7", int'(adD), int'(VECS[i].addr), "address");
    end
    smallOn = 1'b0;

    // R1 reset applied inside a horizontal pulse (counts 899 -> 900)
    while (kCnt != 5124) @(negedge clk);
    check("R4", int'(hsD), 1, "hsync before mid-line reset");
    check("R3", int'(vD), 4, "vcount before mid-line reset");
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(hD), 0, "hcount after mid-line reset");
    check("R1", int'(vD), 0, "vcount after mid-line reset");
    check("R1", int'(hsD), 0, "hsync after mid-line reset");
    check("R1", int'(actD), 0, "active after mid-line reset");
    check("R1", int'(adD), 0, "address after mid-line reset");
    rst = 1'b0;
    @(negedge clk);
    check("R2", int'(hD), 1, "hcount restarts");
    check("R6", int'(actD), 1, "active at origin after reset");
    check("R7", int'(adD), 0, "address at origin after reset");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule